// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the core of one DMA channel. Software programs a source address, a destination address, an element count, the element width of each side, a burst-size code and an address-control mode for each side, then pulses `start`. The sequencer moves the data one element at a time. Each element is a read beat at the current source address followed by a write beat at the current destination address, both issued on a single valid/ready request port. A beat completes in the cycle where `req_valid` and `req_ready` are both high, and read data and the error flag are sampled in that same cycle.

Elements are grouped into bursts. Before each burst the sequencer passes through a wait cycle. If handshake mode is set for a side, the burst is held there until that side's peripheral request line is high. The current addresses and the remaining count are visible at the ports throughout the transfer. Completion, bus errors, bad alignment and aborts are each reported as a single-cycle event pulse.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `busy`, `req_valid` and all three event outputs are low, and `remaining`, `cur_src` and `cur_dst` are zero.
- R2: A `start` pulse accepted while idle raises `busy`. Each element is then a read beat (`req_write`=0) at `cur_src` with `req_size` equal to the source width code, followed by a write beat (`req_write`=1) at `cur_dst` with `req_size` equal to the destination width code. The write carries the data of the preceding read. Width codes are 0=byte, 1=halfword, 2=word, 3=doubleword, and the element size is 1<<code bytes.
- R3: After each completed write beat, each side's address changes according to its own control code: 0 adds the element size, 1 subtracts it, and 2 (or 3) holds it.
- R4: `remaining` loads the programmed count, which is in source-width elements, and drops by one after each completed write beat.
- R5: A burst holds min(2^code, remaining) elements, where the code is clamped to 10. A cycle with no request separates consecutive bursts.
- R6: When a side's handshake bit is 1, no burst begins until that side's request line is high.
- R7: When the last write beat completes, `busy` falls and `tc_evt` pulses for one cycle in the next cycle, with `remaining` at 0. A start with a count of 0 pulses `tc_evt` without issuing any beat.
- R8: A start where either address is not aligned to its element size pulses `err_evt`, issues no beat and leaves `busy`, `remaining`, `cur_src` and `cur_dst` unchanged.
- R9: A beat that completes with `rsp_err` high stops the channel and pulses `err_evt`. The count and addresses are not updated for that element, and `tc_evt` is not raised.
- R10: An `abort` while busy stops the channel in the next cycle and pulses `abt_evt`. A beat accepted in the same cycle as the abort is not counted, and no `tc_evt` is raised even if that beat was the last one. An `abort` while idle has no effect.
- R11: A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| abort | input | 1 | Stop a running transfer |
| src_addr | input | ADDR_W | Programmed source address |
| dst_addr | input | ADDR_W | Programmed destination address |
| xfer_count | input | CNT_W | Element count in source-width units |
| src_width | input | 2 | Source width code |
| dst_width | input | 2 | Destination width code |
| burst_code | input | 4 | Burst-size code, 2^code elements |
| src_actl | input | 2 | Source address control |
| dst_actl | input | 2 | Destination address control |
| src_hs | input | 1 | Source handshake enable |
| dst_hs | input | 1 | Destination handshake enable |
| src_dreq | input | 1 | Source peripheral request |
| dst_dreq | input | 1 | Destination peripheral request |
| req_valid | output | 1 | Beat request valid |
| req_write | output | 1 | 1 = write beat, 0 = read beat |
| req_addr | output | ADDR_W | Beat address |
| req_size | output | 2 | Beat width code |
| req_wdata | output | DATA_W | Write data |
| req_ready | input | 1 | Beat accepted and completed |
| rsp_err | input | 1 | Bus error on the completing beat |
| rsp_rdata | input | DATA_W | Read data of the completing beat |
| busy | output | 1 | Channel running |
| remaining | output | CNT_W | Elements still to move |
| cur_src | output | ADDR_W | Current source address |
| cur_dst | output | ADDR_W | Current destination address |
| tc_evt | output | 1 | Terminal-count pulse |
| err_evt | output | 1 | Error pulse |
| abt_evt | output | 1 | Abort pulse |

## Verification
Two functions can fall in the same cycle: an abort, and the completion of the final write beat, which would otherwise end the transfer with terminal count. The bench provokes this by watching its reference model and raising `abort` together with `req_ready` exactly when the last write is presented. The expected outcome is an abort pulse with no terminal-count pulse and `remaining` left at 1. A second collision, a bus error reported on a beat, is judged the same way: an error pulse with no terminal count, and no update of the count or the addresses.

// File: rtl/dma_seq_pkg.sv
// Shared types and codes of the DMA channel sequencer.
// Assumes: address-control and width codes are two bits wide.
package dma_seq_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} seq_state_t;

    localparam logic [1:0] ACTL_INC = 2'd0;
    localparam logic [1:0] ACTL_DEC = 2'd1;
    localparam logic [1:0] ACTL_FIX = 2'd2;
    localparam int         MAX_BURST_CODE = 10;
endpackage

// File: rtl/dma_addr_unit.sv
// Holds one side's current address and steps it after each finished element.
// Assumes: load and step are never high together (the controller guarantees it).
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic [1:0]        wcode,
    input  logic [1:0]        actl,
    output logic [ADDR_W-1:0] cur
);
    logic [ADDR_W-1:0] stride;

    // Element size in bytes for this side.
    assign stride = ADDR_W'(1) << wcode;

    // Load on start, otherwise move by one element per completed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_addr;
        end else if (step) begin
            case (actl)
                ACTL_INC: cur <= cur + stride;
                ACTL_DEC: cur <= cur - stride;
                default:  cur <= cur;
            endcase
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (!step || actl == ACTL_FIX)) |=> cur == $past(cur)); // R3
    AST_ADDR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && actl == ACTL_DEC) |=> cur == $past(cur) - $past(stride)); // R3
endmodule

// File: rtl/dma_seq_ctrl.sv
// Transfer state machine: start checks, burst grouping, beat sequencing,
// count tracking and the three event pulses.
// Assumes: configuration inputs stay stable while the channel is busy.
module dma_seq_ctrl
    import dma_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              align_bad,
    input  logic [CNT_W-1:0]  count,
    input  logic [3:0]        burst_code,
    input  logic              src_hs,
    input  logic              dst_hs,
    input  logic              src_dreq,
    input  logic              dst_dreq,
    input  logic              req_ready,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rdata,
    output seq_state_t        state,
    output logic [CNT_W-1:0]  remaining,
    output logic [DATA_W-1:0] wdata,
    output logic              load,
    output logic              step,
    output logic              tc_evt,
    output logic              err_evt,
    output logic              abt_evt
);
    logic [CNT_W-1:0] burst_left;
    logic [CNT_W-1:0] burst_len;
    logic [CNT_W-1:0] first_len;
    logic [3:0]       code_eff;
    logic             hs_ok;

    // Clamp the burst code and size the next burst to what remains.
    assign code_eff  = (burst_code > 4'(MAX_BURST_CODE)) ? 4'(MAX_BURST_CODE) : burst_code;
    assign burst_len = CNT_W'(1) << code_eff;
    assign first_len = (remaining < burst_len) ? remaining : burst_len;

    // A burst may begin once every handshaking side is requesting.
    assign hs_ok = (!src_hs || src_dreq) && (!dst_hs || dst_dreq);

    // Address units load on an accepted start and step on a clean write.
    assign load = (state == ST_IDLE) && start && !align_bad;
    assign step = (state == ST_WR) && req_ready && !rsp_err && !abort;

    // Sequencer state, counters, captured read data and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            remaining  <= '0;
            burst_left <= '0;
            wdata      <= '0;
            tc_evt     <= 1'b0;
            err_evt    <= 1'b0;
            abt_evt    <= 1'b0;
        end else begin
            tc_evt  <= 1'b0;
            err_evt <= 1'b0;
            abt_evt <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    if (align_bad) begin
                        err_evt <= 1'b1;
                    end else begin
                        remaining <= count;
                        if (count == '0) tc_evt <= 1'b1;
                        else             state  <= ST_WAIT;
                    end
                end
            end else if (abort) begin
                abt_evt <= 1'b1;
                state   <= ST_IDLE;
            end else if (state == ST_WAIT) begin
                if (hs_ok) begin
                    burst_left <= first_len;
                    state      <= ST_RD;
                end
            end else if (state == ST_RD) begin
                if (req_ready) begin
                    if (rsp_err) begin
                        err_evt <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        wdata <= rdata;
                        state <= ST_WR;
                    end
                end
            end else if (req_ready) begin
                if (rsp_err) begin
                    err_evt <= 1'b1;
                    state   <= ST_IDLE;
                end else begin
                    remaining  <= remaining - 1'b1;
                    burst_left <= burst_left - 1'b1;
                    if (remaining == CNT_W'(1)) begin
                        tc_evt <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (burst_left == CNT_W'(1)) begin
                        state <= ST_WAIT;
                    end else begin
                        state <= ST_RD;
                    end
                end
            end
        end
    end

    AST_HS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !abort && src_hs && !src_dreq) |=> state != ST_RD); // R6
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) |-> (burst_left != '0 && burst_left <= burst_len)); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> remaining == $past(remaining) - 1'b1); // R4
endmodule

// File: rtl/dma_chan_seq.sv
// Top of one DMA channel sequencer: alignment check, beat request mux,
// two address units and the transfer controller.
// Assumes: a beat completes in the cycle req_valid and req_ready are both high.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic [1:0]        src_width,
    input  logic [1:0]        dst_width,
    input  logic [3:0]        burst_code,
    input  logic [1:0]        src_actl,
    input  logic [1:0]        dst_actl,
    input  logic              src_hs,
    input  logic              dst_hs,
    input  logic              src_dreq,
    input  logic              dst_dreq,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_size,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ready,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic [CNT_W-1:0]  remaining,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic              tc_evt,
    output logic              err_evt,
    output logic              abt_evt
);
    seq_state_t        state;
    logic              load;
    logic              step;
    logic              align_bad;
    logic [ADDR_W-1:0] src_mask;
    logic [ADDR_W-1:0] dst_mask;

    // Start-time alignment check of both programmed addresses.
    assign src_mask  = (ADDR_W'(1) << src_width) - 1'b1;
    assign dst_mask  = (ADDR_W'(1) << dst_width) - 1'b1;
    assign align_bad = ((src_addr & src_mask) != '0) || ((dst_addr & dst_mask) != '0);

    // Beat request presented from the controller state.
    assign busy      = (state != ST_IDLE);
    assign req_valid = (state == ST_RD) || (state == ST_WR);
    assign req_write = (state == ST_WR);
    assign req_addr  = req_write ? cur_dst : cur_src;
    assign req_size  = req_write ? dst_width : src_width;

    dma_seq_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .align_bad(align_bad), .count(xfer_count), .burst_code(burst_code),
        .src_hs(src_hs), .dst_hs(dst_hs), .src_dreq(src_dreq), .dst_dreq(dst_dreq),
        .req_ready(req_ready), .rsp_err(rsp_err), .rdata(rsp_rdata),
        .state(state), .remaining(remaining), .wdata(req_wdata),
        .load(load), .step(step),
        .tc_evt(tc_evt), .err_evt(err_evt), .abt_evt(abt_evt)
    );

    dma_addr_unit #(.ADDR_W(ADDR_W)) u_src_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(src_addr),
        .step(step), .wcode(src_width), .actl(src_actl), .cur(cur_src)
    );

    dma_addr_unit #(.ADDR_W(ADDR_W)) u_dst_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(dst_addr),
        .step(step), .wcode(dst_width), .actl(dst_actl), .cur(cur_dst)
    );

    AST_TC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |-> !busy); // R7
    AST_ERR_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> !tc_evt); // R9
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (abt_evt && !busy && !tc_evt)); // R10
    AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> remaining != '0); // R4
    AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && align_bad) |=> (err_evt && !busy)); // R8
endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0;
    logic [31:0] c_src = '0, c_dst = '0;
    logic [15:0] c_cnt = '0;
    logic [1:0]  c_sw = '0, c_dw = '0, c_sa = '0, c_da = '0;
    logic [3:0]  c_bc = '0;
    logic        c_shs = 1'b0, c_dhs = 1'b0, src_dreq = 1'b0, dst_dreq = 1'b0;
    logic        req_valid, req_write, req_ready = 1'b0, rsp_err = 1'b0;
    logic [31:0] req_addr, cur_src, cur_dst;
    logic [1:0]  req_size;
    logic [63:0] req_wdata, rsp_rdata = '0;
    logic        busy, tc_evt, err_evt, abt_evt;
    logic [15:0] remaining;

    always #10 clk = ~clk;

    dma_chan_seq i_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .src_addr(c_src), .dst_addr(c_dst), .xfer_count(c_cnt),
        .src_width(c_sw), .dst_width(c_dw), .burst_code(c_bc),
        .src_actl(c_sa), .dst_actl(c_da), .src_hs(c_shs), .dst_hs(c_dhs),
        .src_dreq(src_dreq), .dst_dreq(dst_dreq),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .busy(busy),
        .remaining(remaining), .cur_src(cur_src), .cur_dst(cur_dst),
        .tc_evt(tc_evt), .err_evt(err_evt), .abt_evt(abt_evt)
    );

    int n_tests = 0, n_fail = 0;
    string cur_tag = "R1";
    // stimulus controls
    logic go_start = 1'b0, rdy_rand = 1'b0, dreq_slow = 1'b0, abort_last = 1'b0;
    int abort_at = -1, err_beat = -1, beat_no = 0, ncyc = 0;
    // reference model: phase 0 idle, 1 wait, 2 read, 3 write
    int m_ph = 0, m_bl = 0;
    logic [15:0] m_rem = '0;
    logic [31:0] m_src = '0, m_dst = '0;
    logic [63:0] m_data = '0;
    logic m_tc = 1'b0, m_err = 1'b0, m_abt = 1'b0;

    task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(logic [31:0] a, logic [1:0] w, logic [1:0] c);
        if (c == 2'd0) return a + (32'd1 << w);
        if (c == 2'd1) return a - (32'd1 << w);
        return a;
    endfunction

    task automatic check_outputs();
        cmp(cur_tag, "busy", busy, m_ph != 0);
        cmp(cur_tag, "req_valid", req_valid, m_ph >= 2);
        cmp("R4", "remaining", remaining, m_rem);
        cmp("R3", "cur_src", cur_src, m_src);
        cmp("R3", "cur_dst", cur_dst, m_dst);
        cmp(cur_tag, "tc_evt", tc_evt, m_tc);
        cmp(cur_tag, "err_evt", err_evt, m_err);
        cmp(cur_tag, "abt_evt", abt_evt, m_abt);
        if (m_ph >= 2) begin
            cmp("R2", "req_write", req_write, m_ph == 3);
            cmp("R2", "req_addr", req_addr, (m_ph == 3) ? m_dst : m_src);
            cmp("R2", "req_size", req_size, (m_ph == 3) ? c_dw : c_sw);
            if (m_ph == 3) cmp("R2", "req_wdata", req_wdata, m_data);
        end
    endtask

    task automatic tick();
        logic lastw, misal, hs;
        int code;
        @(negedge clk);
        check_outputs();
        lastw = (m_ph == 3) && (m_rem == 16'd1);
        start = go_start; go_start = 1'b0;
        abort = (abort_at == ncyc) || (abort_last && lastw);
        req_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
        if (abort_last && lastw) req_ready = 1'b1;
        src_dreq = dreq_slow ? (ncyc % 6 == 0) : 1'b1;
        dst_dreq = dreq_slow ? (ncyc % 4 == 0) : 1'b1;
        rsp_err = 1'b0;
        if (req_valid && req_ready) begin
            if (beat_no == err_beat) rsp_err = 1'b1;
            beat_no++;
        end
        rsp_rdata = {req_addr ^ 32'h5A5A_0000, ~req_addr};
        // model step
        m_tc = 1'b0; m_err = 1'b0; m_abt = 1'b0;
        hs = (!c_shs || src_dreq) && (!c_dhs || dst_dreq);
        if (m_ph == 0) begin
            if (start) begin
                misal = ((c_src % (32'd1 << c_sw)) != 0) || ((c_dst % (32'd1 << c_dw)) != 0);
                if (misal) m_err = 1'b1;
                else begin
                    m_src = c_src; m_dst = c_dst; m_rem = c_cnt;
                    if (c_cnt == 0) m_tc = 1'b1; else m_ph = 1;
                end
            end
        end else if (abort) begin
            m_abt = 1'b1; m_ph = 0;
        end else if (m_ph == 1) begin
            if (hs) begin
                code = (c_bc > 10) ? 10 : int'(c_bc);
                m_bl = ((1 << code) < int'(m_rem)) ? (1 << code) : int'(m_rem);
                m_ph = 2;
            end
        end else if (req_ready) begin
            if (rsp_err) begin
                m_err = 1'b1; m_ph = 0;
            end else if (m_ph == 2) begin
                m_data = rsp_rdata; m_ph = 3;
            end else begin
                m_rem = m_rem - 1'b1; m_bl--;
                m_src = nxt(m_src, c_sw, c_sa);
                m_dst = nxt(m_dst, c_dw, c_da);
                if (m_rem == 0) begin m_tc = 1'b1; m_ph = 0; end
                else m_ph = (m_bl == 0) ? 1 : 2;
            end
        end
        ncyc++;
    endtask

    task automatic xfer(string tag, logic [31:0] s, logic [31:0] d, logic [15:0] n,
                        logic [1:0] sw, logic [1:0] dw, logic [3:0] bc,
                        logic [1:0] sa, logic [1:0] da);
        cur_tag = tag;
        c_src = s; c_dst = d; c_cnt = n; c_sw = sw; c_dw = dw; c_bc = bc;
        c_sa = sa; c_da = da;
        ncyc = 0; beat_no = 0;
        go_start = 1'b1;
        tick();
        for (int g = 0; g < 20000 && m_ph != 0; g++) tick();
        tick(); tick();
        abort_at = -1; err_beat = -1; abort_last = 1'b0; rdy_rand = 1'b0;
        dreq_slow = 1'b0; c_shs = 1'b0; c_dhs = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";
        tick(); tick();
        // R2/R3: byte copy, both incrementing, single-element bursts
        xfer("R2", 32'h100, 32'h200, 16'd4, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0);
        // R3: word source decrementing, halfword destination fixed
        rdy_rand = 1'b1;
        xfer("R3", 32'h1000, 32'h2002, 16'd5, 2'd2, 2'd1, 4'd1, 2'd1, 2'd2);
        // R5: doubleword, bursts of 4 with a shortened last burst
        rdy_rand = 1'b1;
        xfer("R5", 32'h800, 32'h900, 16'd6, 2'd3, 2'd3, 4'd2, 2'd0, 2'd1);
        // R5: oversized burst code clamps, single burst of 3
        xfer("R5", 32'h40, 32'h80, 16'd3, 2'd0, 2'd2, 4'd15, 2'd0, 2'd0);
        // R6: handshake on both sides with sparse requests
        c_shs = 1'b1; c_dhs = 1'b1; dreq_slow = 1'b1;
        xfer("R6", 32'h300, 32'h400, 16'd7, 2'd1, 2'd1, 4'd1, 2'd0, 2'd0);
        // R7: zero count
        xfer("R7", 32'h10, 32'h20, 16'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0);
        // R8: misaligned source, then misaligned destination
        xfer("R8", 32'h1001, 32'h2000, 16'd3, 2'd1, 2'd0, 4'd0, 2'd0, 2'd0);
        xfer("R8", 32'h1000, 32'h2002, 16'd3, 2'd0, 2'd2, 4'd0, 2'd0, 2'd0);
        // R9: bus error on a read beat, then on a write beat
        err_beat = 2;
        xfer("R9", 32'h500, 32'h600, 16'd4, 2'd2, 2'd2, 4'd3, 2'd0, 2'd0);
        err_beat = 5; rdy_rand = 1'b1;
        xfer("R9", 32'h500, 32'h600, 16'd4, 2'd2, 2'd2, 4'd3, 2'd0, 2'd0);
        // R10: abort mid transfer
        abort_at = 5;
        xfer("R10", 32'h700, 32'h780, 16'd8, 2'd0, 2'd0, 4'd2, 2'd0, 2'd0);
        // R10: abort in the same cycle as the final write
        abort_last = 1'b1;
        xfer("R10", 32'h700, 32'h780, 16'd3, 2'd0, 2'd0, 4'd1, 2'd0, 2'd0);
        // R10: abort while idle has no effect
        cur_tag = "R10"; ncyc = 0; abort_at = 1;
        tick(); tick(); tick(); tick();
        abort_at = -1;
        // R11: start pulse while busy is ignored
        xfer("R11", 32'hA00, 32'hB00, 16'd4, 2'd0, 2'd0, 4'd1, 2'd0, 2'd0);
        cur_tag = "R11"; c_cnt = 16'd6; ncyc = 0; beat_no = 0; go_start = 1'b1;
        tick(); tick(); tick();
        go_start = 1'b1;
        for (int g = 0; g < 2000 && m_ph != 0; g++) tick();
        tick(); tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule